// File: doc/BRIEF.md
# Sampled Bipolar Bit Validator

This block sits behind a bipolar line comparator and decides whether the pulses on the line form data bits with legal timing. The comparator delivers two flags: a high-level flag and a low-level flag. Exactly one raised flag marks a one or a zero. Neither raised marks the null level. Both raised is an invalid sample. The block samples the flags on a 1 MHz clock enable, or on every eighth enable when the slow-rate input is set. It keeps a ten-sample history for each level and accepts a bit only when a solid pulse is followed by a solid return to null.

Accepted bits must also be spaced correctly. The distance from one accepted bit to the next must lie between 8 and 12 sample ticks. At 1 MHz this allows roughly 83 to 125 kbit/s in fast mode and roughly 10.4 to 15.6 kbit/s in slow mode. A spacing outside the window raises a one-cycle timing-error pulse. It also drops the reception, and no further bits are reported until the word-framing logic signals through the gap-ready input that a clean inter-word gap has been seen. The first bit after gap-ready has no predecessor, so its spacing is not checked.

Top module: `bipolar_bit_validator`

## Requirements
- R1: After reset all three outputs are low, and no bit strobe is issued until `gap_ready` has been asserted at least once.
- R2: Each sample is classified from the two flags. `lvl_one`=1 with `lvl_zero`=0 is a one. `lvl_one`=0 with `lvl_zero`=1 is a zero. Both low is null. Both high counts toward no level, so it breaks a run of ones or zeros.
- R3: A bit is recognised on the sample tick whose sample completes three consecutive nulls in history stages 2..0 (stage 0 newest). The older stages 9..3 must also hold three consecutive samples of one level. `bit_valid` is high for the single clock cycle after that tick's clock edge, with `bit_value` 1 for a one pulse and 0 for a zero pulse.
- R4: A pulse shorter than three samples is never accepted, and neither is a pulse that is not followed by three null samples. Such a pulse causes neither a strobe nor a timing error. A three-sample pulse is accepted.
- R5: The spacing is the number of ticks from the previous accepted bit. When it is between 8 and 12 inclusive, the bit is strobed. Otherwise `timing_err` pulses for one cycle in place of `bit_valid`.
- R6: After a timing error no bit strobe is issued until `gap_ready` is asserted again. After that, bits are strobed again.
- R7: The first bit recognised after `gap_ready` is strobed regardless of how long ago any earlier bit occurred.
- R8: With `slow_mode`=1, a sample tick occurs only on every eighth `samp_en`, counted from reset. Pulses that last for fewer than three such ticks are rejected. Correctly timed slow-rate bits are accepted with the same 8 to 12 tick window.
- R9: `bit_valid` never stays high for two consecutive cycles and is never high together with `timing_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| samp_en | input | 1 | One-cycle 1 MHz sample enable |
| slow_mode | input | 1 | 1 selects the slow rate (tick on every eighth enable) |
| lvl_one | input | 1 | Comparator flag for the high (one) level |
| lvl_zero | input | 1 | Comparator flag for the low (zero) level |
| gap_ready | input | 1 | Word gap seen; re-arms reception and clears the spacing history |
| bit_valid | output | 1 | One-cycle strobe for an accepted bit |
| bit_value | output | 1 | Value of the last accepted bit |
| timing_err | output | 1 | One-cycle pulse for a bit with illegal spacing |

## Verification
Both `bit_valid` and `timing_err` are registered, so each is due in the single cycle that follows the clock edge on which a sample tick takes in the third trailing null. In slow mode that tick is the eighth enable of a group. The bench drives every input on the falling edge and takes every output 1 ns after the rising edge, so each strobe is counted exactly once. A dedicated latency scenario checks that the strobe is absent after the second null, present right after the third, and gone one cycle later. The remaining scenarios choose pulse and null lengths so that the tick-to-tick spacing between recognised bits is known in advance: 7, 8, 10, 12 or 13.

// File: rtl/bbv_pkg.sv
package bbv_pkg;

    // Classification of one comparator sample.
    typedef enum logic [1:0] {
        LVL_NULL = 2'd0,
        LVL_ONE  = 2'd1,
        LVL_ZERO = 2'd2,
        LVL_BAD  = 2'd3
    } level_e;

    // Per-sample marks fed into the three history registers.
    typedef struct packed {
        logic is_one;
        logic is_zero;
        logic is_null;
    } mark_t;

    // Registered result presented at the ports.
    typedef struct packed {
        logic valid;
        logic value;
        logic err;
    } bit_out_t;

    function automatic level_e decode_level(input logic hi, input logic lo);
        case ({hi, lo})
            2'b00:   return LVL_NULL;
            2'b10:   return LVL_ONE;
            2'b01:   return LVL_ZERO;
            default: return LVL_BAD;
        endcase
    endfunction

    function automatic mark_t to_mark(input level_e lvl);
        mark_t m;
        m.is_one  = (lvl == LVL_ONE);
        m.is_zero = (lvl == LVL_ZERO);
        m.is_null = (lvl == LVL_NULL);
        return m;
    endfunction

endpackage

// File: rtl/bbv_tick_gen.sv
module bbv_tick_gen #(
    parameter int SLOW_DIV = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic samp_en,
    input  logic slow_mode,
    output logic tick
);
    localparam int DW = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
    localparam logic [DW-1:0] LAST = DW'(SLOW_DIV - 1);

    logic [DW-1:0] div_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
        end else if (samp_en) begin
            div_q <= (div_q == LAST) ? '0 : div_q + 1'b1;
        end
    end

    assign tick = samp_en & (~slow_mode | (div_q == LAST));

endmodule

// File: rtl/bbv_history.sv
module bbv_history
    import bbv_pkg::*;
#(
    parameter int HIST_LEN = 10,
    parameter int RUN_LEN  = 3
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  tick,
    input  mark_t mark,
    output logic  hit_one,
    output logic  hit_zero
);
    localparam int NWIN = HIST_LEN - 2 * RUN_LEN + 1;

    logic [HIST_LEN-1:0] one_q, zero_q, null_q;
    logic [HIST_LEN-1:0] one_n, zero_n, null_n;
    logic [NWIN-1:0]     win_one, win_zero;
    logic                null_tail;
    logic                seen_any;

    assign one_n  = {one_q[HIST_LEN-2:0],  mark.is_one};
    assign zero_n = {zero_q[HIST_LEN-2:0], mark.is_zero};
    assign null_n = {null_q[HIST_LEN-2:0], mark.is_null};

    // Scan every run-length window in the older stages for a solid level.
    genvar k;
    for (k = 0; k < NWIN; k++) begin : g_win
        assign win_one[k]  = &one_n[RUN_LEN + k +: RUN_LEN];
        assign win_zero[k] = &zero_n[RUN_LEN + k +: RUN_LEN];
    end

    assign null_tail = &null_n[RUN_LEN-1:0];
    assign hit_one   = tick & null_tail & (|win_one);
    assign hit_zero  = tick & null_tail & (|win_zero);
    assign seen_any  = hit_one | hit_zero;

    always_ff @(posedge clk) begin
        if (rst) begin
            one_q  <= '0;
            zero_q <= '0;
            null_q <= '0;
        end else if (tick) begin
            one_q  <= seen_any ? '0 : one_n;
            zero_q <= seen_any ? '0 : zero_n;
            null_q <= null_n;
        end
    end

endmodule

// File: rtl/bbv_spacing.sv
module bbv_spacing #(
    parameter int SPACE_MIN = 8,
    parameter int SPACE_MAX = 12
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic bit_seen,
    input  logic gap_ready,
    output logic accept,
    output logic reject
);
    localparam int CW = $clog2(SPACE_MAX + 2);
    localparam logic [CW-1:0] CNT_CAP = CW'(SPACE_MAX + 1);
    localparam logic [CW-1:0] LO_LIM  = CW'(SPACE_MIN);
    localparam logic [CW-1:0] HI_LIM  = CW'(SPACE_MAX);

    logic          armed_q;
    logic          have_prev_q;
    logic [CW-1:0] gap_cnt_q;
    logic [CW-1:0] spacing;
    logic          bad_space;

    assign spacing   = gap_cnt_q + 1'b1;
    assign bad_space = have_prev_q & ((spacing < LO_LIM) | (spacing > HI_LIM));
    assign accept    = bit_seen & armed_q & ~bad_space;
    assign reject    = bit_seen & armed_q & bad_space;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q     <= 1'b0;
            have_prev_q <= 1'b0;
            gap_cnt_q   <= '0;
        end else if (gap_ready) begin
            armed_q     <= 1'b1;
            have_prev_q <= 1'b0;
            gap_cnt_q   <= '0;
        end else if (reject) begin
            armed_q     <= 1'b0;
            have_prev_q <= 1'b0;
            gap_cnt_q   <= '0;
        end else if (accept) begin
            have_prev_q <= 1'b1;
            gap_cnt_q   <= '0;
        end else if (tick && gap_cnt_q != CNT_CAP) begin
            gap_cnt_q <= gap_cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/bipolar_bit_validator.sv
module bipolar_bit_validator
    import bbv_pkg::*;
#(
    parameter int HIST_LEN  = 10,
    parameter int RUN_LEN   = 3,
    parameter int SPACE_MIN = 8,
    parameter int SPACE_MAX = 12,
    parameter int SLOW_DIV  = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic samp_en,
    input  logic slow_mode,
    input  logic lvl_one,
    input  logic lvl_zero,
    input  logic gap_ready,
    output logic bit_valid,
    output logic bit_value,
    output logic timing_err
);
    logic     tick;
    mark_t    mark;
    logic     hit_one, hit_zero, bit_seen;
    logic     accept, reject;
    bit_out_t res_q;

    assign mark = to_mark(decode_level(lvl_one, lvl_zero));

    bbv_tick_gen #(.SLOW_DIV(SLOW_DIV)) u_tick (
        .clk       (clk),
        .rst       (rst),
        .samp_en   (samp_en),
        .slow_mode (slow_mode),
        .tick      (tick)
    );

    bbv_history #(.HIST_LEN(HIST_LEN), .RUN_LEN(RUN_LEN)) u_hist (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .mark     (mark),
        .hit_one  (hit_one),
        .hit_zero (hit_zero)
    );

    // A window holding runs of both levels is ambiguous and is dropped.
    assign bit_seen = hit_one ^ hit_zero;

    bbv_spacing #(.SPACE_MIN(SPACE_MIN), .SPACE_MAX(SPACE_MAX)) u_space (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .bit_seen  (bit_seen),
        .gap_ready (gap_ready),
        .accept    (accept),
        .reject    (reject)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
        end else begin
            res_q.valid <= accept;
            res_q.err   <= reject;
            if (accept) res_q.value <= hit_one;
        end
    end

    assign bit_valid  = res_q.valid;
    assign bit_value  = res_q.value;
    assign timing_err = res_q.err;

endmodule

// File: rtl/bbv_checker.sv
module bbv_checker (
    input logic clk,
    input logic rst,
    input logic samp_en,
    input logic gap_ready,
    input logic bit_valid,
    input logic timing_err
);
    logic armed_seen;

    always_ff @(posedge clk) begin
        if (rst)            armed_seen <= 1'b0;
        else if (gap_ready) armed_seen <= 1'b1;
    end

    // R1: no strobe before the first gap_ready
    p_no_strobe_unarmed_r1: assert property (@(posedge clk) disable iff (rst)
        bit_valid |-> armed_seen);

    // R3: a strobe always follows a sample enable
    p_strobe_after_enable_r3: assert property (@(posedge clk) disable iff (rst)
        bit_valid |-> $past(samp_en));

    // R5: the error is a single-cycle pulse
    p_err_single_r5: assert property (@(posedge clk) disable iff (rst)
        timing_err |=> !timing_err);

    // R6: an error blocks the strobe in the following cycle
    p_err_blocks_r6: assert property (@(posedge clk) disable iff (rst)
        timing_err |=> !bit_valid);

    // R9: strobe lasts one cycle
    p_strobe_single_r9: assert property (@(posedge clk) disable iff (rst)
        bit_valid |=> !bit_valid);

    // R9: strobe and error are exclusive
    p_strobe_err_excl_r9: assert property (@(posedge clk) disable iff (rst)
        !(bit_valid && timing_err));

endmodule

bind bipolar_bit_validator bbv_checker chk_i (
    .clk        (clk),
    .rst        (rst),
    .samp_en    (samp_en),
    .gap_ready  (gap_ready),
    .bit_valid  (bit_valid),
    .timing_err (timing_err)
);

// File: tb/bipolar_bit_validator_tb_top.sv
`timescale 1ns/1ps
module bipolar_bit_validator_tb_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic samp_en = 1'b0;
    logic slow_mode = 1'b0;
    logic lvl_one = 1'b0;
    logic lvl_zero = 1'b0;
    logic gap_ready = 1'b0;
    logic bit_valid, bit_value, timing_err;

    int n_checks = 0;
    int n_fail = 0;
    int n_valid = 0;
    int n_err = 0;
    logic [31:0] cap = '0;
    bit done = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    bipolar_bit_validator dut_i (
        .clk        (clk),
        .rst        (rst),
        .samp_en    (samp_en),
        .slow_mode  (slow_mode),
        .lvl_one    (lvl_one),
        .lvl_zero   (lvl_zero),
        .gap_ready  (gap_ready),
        .bit_valid  (bit_valid),
        .bit_value  (bit_value),
        .timing_err (timing_err)
    );

    // Output monitor, sampling 1 ns after each rising edge.
    always @(posedge clk) begin
        #1;
        if (bit_valid) begin
            n_valid++;
            cap = {cap[30:0], bit_value};
        end
        if (timing_err) n_err++;
    end

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_counts();
        n_valid = 0;
        n_err = 0;
        cap = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; samp_en = 1'b0; gap_ready = 1'b0;
        lvl_one = 1'b0; lvl_zero = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        clear_counts();
    endtask

    task automatic pulse_gap();
        @(negedge clk); gap_ready = 1'b1;
        @(negedge clk); gap_ready = 1'b0;
    endtask

    // One sample enable carrying the given flags; four clocks long.
    task automatic samp(input logic o, input logic z);
        @(negedge clk);
        lvl_one = o; lvl_zero = z; samp_en = 1'b1;
        @(negedge clk);
        samp_en = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // One sample tick worth of enables for the current mode.
    task automatic tick_lvl(input logic o, input logic z, input bit slow);
        repeat (slow ? 8 : 1) samp(o, z);
    endtask

    task automatic send_bit(input logic val, input int w, input int n, input bit slow);
        for (int i = 0; i < w; i++) tick_lvl(val, ~val, slow);
        for (int i = 0; i < n; i++) tick_lvl(1'b0, 1'b0, slow);
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 reset outputs", {bit_valid, bit_value, timing_err}, 0);
        send_bit(1'b1, 5, 5, 1'b0);
        send_bit(1'b0, 5, 5, 1'b0);
        check("R1 no strobe before gap_ready", n_valid, 0);
        check("R1 no error before gap_ready", n_err, 0);
    endtask

    task automatic t_basic();
        do_reset();
        pulse_gap();
        send_bit(1'b1, 5, 5, 1'b0);
        send_bit(1'b0, 5, 5, 1'b0);
        send_bit(1'b1, 5, 5, 1'b0);
        send_bit(1'b1, 5, 5, 1'b0);
        send_bit(1'b0, 5, 5, 1'b0);
        check("R3 strobe count", n_valid, 5);
        check("R3 bit values 10110", int'(cap[4:0]), 5'b10110);
        check("R7 first bit unchecked, no error", n_err, 0);
    endtask

    task automatic t_latency();
        do_reset();
        pulse_gap();
        for (int i = 0; i < 5; i++) samp(1'b0, 1'b1);
        samp(1'b0, 1'b0);
        samp(1'b0, 1'b0);
        check("R3 no strobe after second null", int'(bit_valid), 0);
        @(negedge clk);
        lvl_one = 1'b0; lvl_zero = 1'b0; samp_en = 1'b1;
        @(negedge clk);
        samp_en = 1'b0;
        check("R3 strobe right after third null", int'(bit_valid), 1);
        check("R3 zero pulse gives value 0", int'(bit_value), 0);
        @(negedge clk);
        check("R9 strobe lasts one cycle", int'(bit_valid), 0);
    endtask

    task automatic t_window();
        do_reset();
        pulse_gap();
        send_bit(1'b1, 4, 4, 1'b0);
        send_bit(1'b0, 4, 4, 1'b0);
        send_bit(1'b1, 4, 4, 1'b0);
        send_bit(1'b1, 4, 8, 1'b0);
        send_bit(1'b0, 4, 8, 1'b0);
        send_bit(1'b1, 4, 4, 1'b0);
        check("R5 spacings 8 and 12 strobed", n_valid, 6);
        check("R5 window values", int'(cap[5:0]), 6'b101101);
        check("R5 no error inside window", n_err, 0);
    endtask

    task automatic t_short_space();
        do_reset();
        pulse_gap();
        send_bit(1'b1, 4, 6, 1'b0);
        send_bit(1'b0, 4, 3, 1'b0);
        send_bit(1'b1, 4, 6, 1'b0);
        check("R5 spacing 7 raises error", n_err, 1);
        check("R5 spacing 7 not strobed", n_valid, 2);
        send_bit(1'b1, 4, 6, 1'b0);
        send_bit(1'b1, 4, 6, 1'b0);
        check("R6 no strobe after error", n_valid, 2);
        pulse_gap();
        send_bit(1'b0, 4, 6, 1'b0);
        send_bit(1'b0, 4, 6, 1'b0);
        check("R6 strobes resume after gap_ready", n_valid, 4);
        check("R7 no error after re-arm", n_err, 1);
    endtask

    task automatic t_long_space();
        do_reset();
        pulse_gap();
        send_bit(1'b1, 4, 9, 1'b0);
        send_bit(1'b1, 4, 6, 1'b0);
        check("R5 spacing 13 raises error", n_err, 1);
        check("R5 spacing 13 not strobed", n_valid, 1);
    endtask

    task automatic t_both_high();
        do_reset();
        pulse_gap();
        samp(1'b1, 1'b0); samp(1'b1, 1'b0); samp(1'b1, 1'b1);
        samp(1'b1, 1'b0); samp(1'b1, 1'b0);
        for (int i = 0; i < 6; i++) samp(1'b0, 1'b0);
        check("R2 both-high sample breaks run", n_valid, 0);
        send_bit(1'b0, 5, 5, 1'b0);
        check("R2 clean zero accepted", n_valid, 1);
        check("R2 zero level gives value 0", int'(cap[0]), 0);
    endtask

    task automatic t_min_width();
        do_reset();
        pulse_gap();
        send_bit(1'b1, 2, 8, 1'b0);
        check("R4 two-sample pulse rejected", n_valid + n_err, 0);
        send_bit(1'b1, 3, 7, 1'b0);
        check("R4 three-sample pulse accepted", n_valid, 1);
    endtask

    task automatic t_slow();
        slow_mode = 1'b1;
        do_reset();
        pulse_gap();
        // Fast-length pulse: only one tick lands on it.
        for (int i = 0; i < 5; i++) samp(1'b0, 1'b0);
        for (int i = 0; i < 3; i++) samp(1'b1, 1'b0);
        for (int i = 0; i < 3; i++) tick_lvl(1'b0, 1'b0, 1'b1);
        check("R8 short pulse rejected in slow mode", n_valid + n_err, 0);
        send_bit(1'b1, 5, 5, 1'b1);
        send_bit(1'b0, 5, 5, 1'b1);
        check("R8 slow bits strobed", n_valid, 2);
        check("R8 slow bit values", int'(cap[1:0]), 2'b10);
        check("R8 slow spacing legal", n_err, 0);
        slow_mode = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        t_reset();
        t_basic();
        t_latency();
        t_window();
        t_short_space();
        t_long_space();
        t_both_high();
        t_min_width();
        t_slow();
        finish_run();
    end

endmodule